// File: doc/BRIEF.md
# Two-Wire Serial Shift Interface

This block is an 8-bit serial shift port for a small controller-style peripheral. It exchanges a byte over one data-out line and one data-in line, most significant bit first, and is clocked either by an external clock, by a timer output, or by one of two internally divided system clocks. Both data pins are open-drain: the block only pulls a pin low, and the line is otherwise released to its pull-up.

Software programs a mode register, whose pin field chooses which of the two pins carries outgoing data and which one is sampled, and whose clock field chooses the shift clock source and the direction of the clock pin. Writing the shift register starts a transfer. Data leaves on falling clock edges, data is captured on rising edges, and after eight rising edges a done flag is raised. A write-only trigger bit in the control register forces the output latch low in one step and never reads back as set.

Top module: `twsio_core`

## Requirements
- R1: After reset the mode, control and shift registers read 0x00 (read selects 0, 1 and 2), `xfer_done` is 0, both pin enables are 0 and `sck_oe` is 0.
- R2: With the pin field (mode bits [4:2]) equal to 3'b011, outgoing bits appear on pin 0 and incoming bits are taken from pin 1; the byte goes out most significant bit first.
- R3: With the pin field equal to 3'b111, outgoing bits appear on pin 1 and incoming bits are taken from pin 0.
- R4: With any other pin field value, both pins stay released, no shift clock is produced and writing the shift register does not set `xfer_done`.
- R5: Clock field (mode bits [1:0]) 2'b00 shifts on edges of `sck_in` and holds `sck_oe` at 0.
- R6: Clock field 2'b01 shifts on edges of `tmr_in`, drives `sck_oe` to 1 and presents the timer level on `sck_out`.
- R7: Clock field 2'b10 drives `sck_oe` to 1 and produces a shift clock on `sck_out` with a period of 64 system clocks.
- R8: Clock field 2'b11 drives `sck_oe` to 1 and produces a shift clock on `sck_out` with a period of 8 system clocks.
- R9: Outgoing data changes after falling shift-clock edges, incoming data is sampled on rising edges; after the eighth rising edge `xfer_done` is 1 and the shift register (read select 2) holds the received byte; a write to the shift register (write select 2) clears `xfer_done`.
- R10: Writing the control register (write select 1) with bit 1 set forces the output latch low, so the active data pin is pulled low; bit 1 always reads back as 0.
- R11: The other control register bits read back as written and do not change the data pins.
- R12: A data pin's enable is 1 only when the latched output bit is 0; a latched 1 releases the pin, and the two enables are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mode, 1 control, 2 shift |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read target: 0 mode, 1 control, 2 shift |
| rd_data | output | 8 | Registered read data, one cycle after `rd_sel` |
| sck_in | input | 1 | External shift clock |
| tmr_in | input | 1 | Timer output used as shift clock |
| sck_out | output | 1 | Shift clock driven out when the clock pin is an output |
| sck_oe | output | 1 | Clock pin output enable |
| pin0_in | input | 1 | Line level of data pin 0 |
| pin0_oe | output | 1 | Pull pin 0 low |
| pin1_in | input | 1 | Line level of data pin 1 |
| pin1_oe | output | 1 | Pull pin 1 low |
| xfer_done | output | 1 | End-of-transfer flag |

## Verification
The bench swaps the pin roles between the two mode encodings and checks that the bits arrive on the chosen pin in most-significant-first order; a design with the roles crossed or the order reversed would mismatch the first differing bit. It measures the divided clock periods, so a divider off by a factor of two or off by one toggle would show a wrong period, and it clocks exactly eight edges from external and timer sources, so a bit counter stopping at seven or nine would leave the done flag wrong or the received byte shifted. The command trigger is checked at the pin and at the read port, catching a trigger that fails to pull the line low or that sticks at 1, and an invalid pin field is checked to leave both pins released and the done flag clear.

// File: rtl/twsio_pkg.sv
package twsio_pkg;

  typedef enum logic [1:0] {
    CK_EXT  = 2'b00,
    CK_TMR  = 2'b01,
    CK_SLOW = 2'b10,
    CK_FAST = 2'b11
  } ck_sel_e;

  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_CTRL  = 2'd1,
    REG_SHIFT = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  localparam logic [2:0] PINS_PRI = 3'b011;
  localparam logic [2:0] PINS_ALT = 3'b111;
  localparam int         CMD_BIT  = 1;

endpackage

// File: rtl/twsio_clkgen.sv
module twsio_clkgen
  import twsio_pkg::*;
#(
  parameter int DIV_SLOW    = 64,
  parameter int DIV_FAST    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  ck_sel_e ck_sel,
  input  logic    run,
  input  logic    sck_in,
  input  logic    tmr_in,
  output logic    sck_out,
  output logic    sck_oe,
  output logic    rise,
  output logic    fall
);

  localparam int HALF_SLOW = DIV_SLOW / 2;
  localparam int HALF_FAST = DIV_FAST / 2;
  localparam int HALF_MAX  = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int CW        = $clog2(HALF_MAX + 1);

  logic [SYNC_STAGES-1:0] sck_sync, tmr_sync;
  logic                   sck_s, tmr_s;
  logic [CW-1:0]          div_cnt, half_m1;
  logic                   gen, internal, lvl, lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sync <= '1;
      tmr_sync <= '1;
    end else begin
      sck_sync <= {sck_sync[SYNC_STAGES-2:0], sck_in};
      tmr_sync <= {tmr_sync[SYNC_STAGES-2:0], tmr_in};
    end
  end

  assign sck_s    = sck_sync[SYNC_STAGES-1];
  assign tmr_s    = tmr_sync[SYNC_STAGES-1];
  assign internal = (ck_sel == CK_SLOW) || (ck_sel == CK_FAST);
  assign half_m1  = (ck_sel == CK_SLOW) ? CW'(HALF_SLOW - 1) : CW'(HALF_FAST - 1);

  // Divided clock idles high and only toggles during a transfer.
  always_ff @(posedge clk) begin
    if (rst || !run || !internal) begin
      gen     <= 1'b1;
      div_cnt <= '0;
    end else if (div_cnt == half_m1) begin
      gen     <= ~gen;
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_comb begin
    unique case (ck_sel)
      CK_EXT:  lvl = sck_s;
      CK_TMR:  lvl = tmr_s;
      default: lvl = gen;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= 1'b1;
      sck_out <= 1'b1;
      sck_oe  <= 1'b0;
    end else begin
      lvl_q   <= lvl;
      sck_out <= internal ? gen : tmr_s;
      sck_oe  <= (ck_sel != CK_EXT);
    end
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;

endmodule

// File: rtl/twsio_shifter.sv
module twsio_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          enable,
  input  logic          rise,
  input  logic          fall,
  input  logic          si,
  input  logic          cmd_clr,
  output logic          busy,
  output logic          done,
  output logic          so_latch,
  output logic [DW-1:0] sr
);

  localparam int NW = $clog2(DW);

  logic [NW-1:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      bit_cnt <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else if (load) begin
      sr      <= load_data;
      bit_cnt <= '0;
      busy    <= enable;
      done    <= 1'b0;
    end else if (busy && rise) begin
      sr <= {sr[DW-2:0], si};
      if (bit_cnt == NW'(DW - 1)) begin
        bit_cnt <= '0;
        busy    <= 1'b0;
        done    <= 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // Output latch: the command trigger takes priority over a falling edge.
  always_ff @(posedge clk) begin
    if (rst)                       so_latch <= 1'b1;
    else if (cmd_clr)              so_latch <= 1'b0;
    else if (busy && fall && !load) so_latch <= sr[DW-1];
  end

endmodule

// File: rtl/twsio_pins.sv
module twsio_pins (
  input  logic clk,
  input  logic rst,
  input  logic pins_valid,
  input  logic pins_alt,
  input  logic so_latch,
  input  logic pin0_in,
  input  logic pin1_in,
  output logic pin0_oe,
  output logic pin1_oe,
  output logic si
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin0_oe <= 1'b0;
      pin1_oe <= 1'b0;
      si      <= 1'b1;
    end else begin
      pin0_oe <= pins_valid && !pins_alt && !so_latch;
      pin1_oe <= pins_valid &&  pins_alt && !so_latch;
      si      <= pins_alt ? pin0_in : pin1_in;
    end
  end

endmodule

// File: rtl/twsio_core.sv
module twsio_core
  import twsio_pkg::*;
#(
  parameter int DW          = 8,
  parameter int DIV_SLOW    = 64,
  parameter int DIV_FAST    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          sck_in,
  input  logic          tmr_in,
  output logic          sck_out,
  output logic          sck_oe,
  input  logic          pin0_in,
  output logic          pin0_oe,
  input  logic          pin1_in,
  output logic          pin1_oe,
  output logic          xfer_done
);

  localparam logic [DW-1:0] CMD_MASK = DW'(1) << CMD_BIT;

  logic [DW-1:0] mode_q, ctrl_q, sr;
  logic          pins_valid, pins_alt, cmd_clr, load;
  logic          busy, so_latch, si, rise, fall;
  ck_sel_e       ck_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (reg_sel_e'(wr_sel) == REG_MODE) mode_q <= wr_data;
      if (reg_sel_e'(wr_sel) == REG_CTRL) ctrl_q <= wr_data & ~CMD_MASK;
    end
  end

  assign pins_valid = (mode_q[4:2] == PINS_PRI) || (mode_q[4:2] == PINS_ALT);
  assign pins_alt   = mode_q[4];
  assign ck_sel     = ck_sel_e'(mode_q[1:0]);
  assign cmd_clr    = wr_en && (reg_sel_e'(wr_sel) == REG_CTRL) && wr_data[CMD_BIT];
  assign load       = wr_en && (reg_sel_e'(wr_sel) == REG_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      unique case (reg_sel_e'(rd_sel))
        REG_MODE:  rd_data <= mode_q;
        REG_CTRL:  rd_data <= ctrl_q;
        REG_SHIFT: rd_data <= sr;
        default:   rd_data <= '0;
      endcase
    end
  end

  twsio_clkgen #(
    .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .SYNC_STAGES(SYNC_STAGES)
  ) u_clk (
    .clk(clk), .rst(rst), .ck_sel(ck_sel), .run(busy),
    .sck_in(sck_in), .tmr_in(tmr_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .rise(rise), .fall(fall)
  );

  twsio_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .load(load), .load_data(wr_data),
    .enable(pins_valid), .rise(rise), .fall(fall), .si(si),
    .cmd_clr(cmd_clr), .busy(busy), .done(xfer_done),
    .so_latch(so_latch), .sr(sr)
  );

  twsio_pins u_pins (
    .clk(clk), .rst(rst), .pins_valid(pins_valid), .pins_alt(pins_alt),
    .so_latch(so_latch), .pin0_in(pin0_in), .pin1_in(pin1_in),
    .pin0_oe(pin0_oe), .pin1_oe(pin1_oe), .si(si)
  );

endmodule

// File: rtl/twsio_chk.sv
module twsio_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] mode_q,
  input logic          so_latch,
  input logic          pin0_oe,
  input logic          pin1_oe,
  input logic          sck_oe,
  input logic          xfer_done
);

  AST_PINS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(pin0_oe && pin1_oe)) else $error("both data pins enabled"); // R12

  AST_LATCH_HIGH_RELEASES: assert property (@(posedge clk) disable iff (rst)
    so_latch |=> (!pin0_oe && !pin1_oe)) else $error("pin held low on latched 1"); // R12

  AST_BAD_PINS_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !((mode_q[4:2] == 3'b011) || (mode_q[4:2] == 3'b111)) |=> (!pin0_oe && !pin1_oe))
    else $error("pin driven in invalid pin mode"); // R4

  AST_CLOCK_PIN_DIR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sck_oe == ($past(mode_q[1:0]) != 2'b00)))
    else $error("clock pin direction mismatch"); // R5

  AST_CMD_CLEARS_LATCH: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd1 && wr_data[1]) |=> !so_latch)
    else $error("command trigger did not clear latch"); // R10

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd2) |=> !xfer_done)
    else $error("done flag survived a new transfer"); // R9

endmodule

bind twsio_core twsio_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .mode_q(mode_q), .so_latch(so_latch), .pin0_oe(pin0_oe), .pin1_oe(pin1_oe),
  .sck_oe(sck_oe), .xfer_done(xfer_done)
);

// File: tb/tb_twsio_core.sv
module tb_twsio_core;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       sck_in = 1'b1, tmr_in = 1'b1;
  logic       sck_out, sck_oe, pin0_in, pin0_oe, pin1_in, pin1_oe, xfer_done;
  logic       p0_drv = 1'b1, p1_drv = 1'b1;

  assign pin0_in = pin0_oe ? 1'b0 : p0_drv;
  assign pin1_in = pin1_oe ? 1'b0 : p1_drv;

  twsio_core dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .sck_in(sck_in), .tmr_in(tmr_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .pin0_in(pin0_in), .pin0_oe(pin0_oe),
    .pin1_in(pin1_in), .pin1_oe(pin1_oe), .xfer_done(xfer_done)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard state
  logic  exp_q[$];
  string mon_req = "";
  bit    mon_on = 0, mon_alt = 0, per_done = 0;
  logic [7:0] rx_byte = '0;
  int    rx_idx = 0, per_exp = 0, last_fall = -1;
  logic  bus_q = 1'b1;

  // Monitor: pops expected outgoing bits on rising shift-clock edges,
  // plays the far end by driving the next incoming bit after each falling edge.
  always @(negedge clk) begin
    logic bus, line, e;
    cyc++;
    bus = sck_oe ? sck_out : sck_in;
    if (mon_on && bus && !bus_q) begin
      line = mon_alt ? pin1_in : pin0_in;
      if (exp_q.size() == 0) chk({mon_req, " extra bit R9"}, 32'd1, 32'd0);
      else begin
        e = exp_q.pop_front();
        chk({mon_req, " out bit"}, {31'd0, line}, {31'd0, e});
      end
    end
    if (mon_on && !bus && bus_q) begin
      if (rx_idx < 8) begin
        if (mon_alt) p0_drv = rx_byte[7 - rx_idx];
        else         p1_drv = rx_byte[7 - rx_idx];
        rx_idx++;
      end
      if (per_exp != 0 && !per_done && last_fall >= 0) begin
        chk({mon_req, " clock period"}, cyc - last_fall, per_exp);
        per_done = 1;
      end
      last_fall = cyc;
    end
    bus_q = bus;
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic run_xfer(input string req, input logic [2:0] pins, input logic [1:0] csel,
                          input logic [7:0] tx, input logic [7:0] rx, input int per);
    logic [7:0] got;
    int w;
    wr(2'd0, {3'b000, pins, csel});
    repeat (4) @(negedge clk);
    chk({req, " clock pin dir"}, {31'd0, sck_oe}, {31'd0, csel != 2'b00});
    mon_req = req; mon_alt = (pins == 3'b111);
    p0_drv = 1'b1; p1_drv = 1'b1;
    for (int i = 7; i >= 0; i--) exp_q.push_back(tx[i]);
    rx_byte = rx; rx_idx = 0; per_exp = per; per_done = 0; last_fall = -1;
    mon_on = 1;
    wr(2'd2, tx);
    chk({req, " done cleared by start R9"}, {31'd0, xfer_done}, 32'd0);
    if (csel == 2'b00 || csel == 2'b01) begin
      for (int b = 0; b < 8; b++) begin
        #1; if (csel == 2'b00) sck_in = 1'b0; else tmr_in = 1'b0;
        repeat (12) @(negedge clk);
        #1; if (csel == 2'b00) sck_in = 1'b1; else tmr_in = 1'b1;
        repeat (12) @(negedge clk);
      end
    end
    w = 0;
    while (!xfer_done && w < 3000) begin @(negedge clk); w++; end
    chk({req, " done flag R9"}, {31'd0, xfer_done}, 32'd1);
    repeat (4) @(negedge clk);
    mon_on = 0;
    chk({req, " bits left R9"}, exp_q.size(), 32'd0);
    exp_q.delete();
    if (per != 0) chk({req, " period measured"}, {31'd0, per_done}, 32'd1);
    rd(2'd2, got);
    chk({req, " received byte R9"}, got, rx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 mode reg", d, 8'h00);
    rd(2'd1, d); chk("R1 ctrl reg", d, 8'h00);
    rd(2'd2, d); chk("R1 shift reg", d, 8'h00);
    chk("R1 done", {31'd0, xfer_done}, 32'd0);
    chk("R1 pin enables", {30'd0, pin1_oe, pin0_oe}, 32'd0);
    chk("R1 clock pin dir", {31'd0, sck_oe}, 32'd0);

    // R4 invalid pin field: nothing shifts, pins released
    wr(2'd0, 8'b000_000_11);
    wr(2'd2, 8'h00);
    repeat (100) @(negedge clk);
    chk("R4 no done", {31'd0, xfer_done}, 32'd0);
    chk("R4 pins released", {30'd0, pin1_oe, pin0_oe}, 32'd0);
    chk("R4 no shift clock", {31'd0, sck_out}, 32'd1);

    // R12, R11, R10 on pin 0 with idle latch = 1
    wr(2'd0, 8'b000_011_11);
    repeat (3) @(negedge clk);
    chk("R12 latched 1 releases pin", {31'd0, pin0_oe}, 32'd0);
    chk("R8 clock pin output", {31'd0, sck_oe}, 32'd1);
    wr(2'd1, 8'hFD);
    repeat (3) @(negedge clk);
    rd(2'd1, d); chk("R11 ctrl readback", d, 8'hFD);
    chk("R11 no pin effect", {31'd0, pin0_oe}, 32'd0);
    wr(2'd1, 8'hFF);
    repeat (3) @(negedge clk);
    chk("R10 pin pulled low", {31'd0, pin0_oe}, 32'd1);
    chk("R10 line level", {31'd0, pin0_in}, 32'd0);
    chk("R12 other pin idle", {31'd0, pin1_oe}, 32'd0);
    rd(2'd1, d); chk("R10 trigger reads 0", d, 8'hFD);

    // Transfers
    run_xfer("R2 R8 fast", 3'b011, 2'b11, 8'hA5, 8'h3C, 8);
    run_xfer("R3 R7 slow", 3'b111, 2'b10, 8'h5A, 8'hC3, 64);
    run_xfer("R5 external", 3'b011, 2'b00, 8'h81, 8'h7E, 0);
    run_xfer("R6 timer", 3'b111, 2'b01, 8'hFF, 8'h00, 0);
    run_xfer("R2 R12 zeros", 3'b011, 2'b11, 8'h00, 8'hFF, 8);
    chk("R12 latched 0 drives pin", {31'd0, pin0_oe}, 32'd1);
    run_xfer("R3 R12 ones", 3'b111, 2'b11, 8'h01, 8'h96, 8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule